// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Controller

This block is the slave end of a serial EEPROM port that runs in SPI mode 0. A host selects the device by pulling the active-low select low. It then clocks in an 8-bit command, most significant bit first. Depending on the command, a 16-bit byte address and data bytes follow. Read data is taken from a byte array outside the block and is shifted out on the serial output. Write data is passed, one byte at a time, to a separate page-write unit, along with a start pulse when the host releases select. An external protection checker answers for each addressed location whether a write is allowed there. The page-write unit reports through a busy input while it programs.

The block runs on a system clock that is much faster than the serial clock. Select, serial clock and serial input pass through two-stage synchronisers. Edges are then detected on the synchronised copies. The output enable follows the raw select pin, so the output floats as soon as select goes high.

Top module: `spi_eeprom_slave`

## Requirements
- R1: Each frame begins with select falling and ends with select rising. Bits are taken on rising serial-clock edges, MSB first. Command bits 7..4 must be zero and bit 3 is ignored. Bits 2..0 select the command: 110 set latch, 100 clear latch, 101 status read, 001 status write, 011 read, 010 write. Any other code is dropped for the rest of the frame.
- R2: A read takes two address bytes, high byte first. Only the low ADDR_W bits are kept. Data leaves MSB first, with bit 7 valid before the first data rising edge. Output bits change on falling edges. The address then increments per byte and wraps from the top of the array to 0.
- R3: Serial input is ignored during the data phase of a read.
- R4: The set-latch command sets the write-enable latch and the clear-latch command clears it. The latch is status bit 1.
- R5: A status read returns {wpen, 0, 0, 0, bp[1], bp[0], latch, 0} and repeats it for every further byte. While wr_busy is high it returns 8'hFF instead.
- R6: A write or status write with the latch clear has no effect for the rest of that frame: no strobe, no start pulse, no status change.
- R7: For each complete write data byte, if wr_allow is high, the block raises wr_stb for one cycle with wr_data and mem_addr. After every data byte, whether accepted or refused, the low PAGE_W address bits increment and wrap inside the page. The upper address bits stay fixed.
- R8: When select rises after a write or status write that accepted at least one byte, wr_go pulses for one cycle and the latch clears.
- R9: While wr_busy is high, every command except status read is dropped.
- R10: A permitted status write loads wpen from data bit 7 and bp from bits 3..2. prot_cfg shows {wpen, bp}.
- R11: so_en is high only during the data phase of a read or a status read, and is low whenever cs_n is high.
- R12: Reset clears the latch, wpen, bp and all frame state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_en | output | 1 | Output enable for so (tri-state control) |
| mem_addr | output | ADDR_W | Current byte address |
| mem_rdata | input | 8 | Array data at mem_addr |
| wr_allow | input | 1 | Protection check: a write at mem_addr is permitted |
| wr_busy | input | 1 | Page-write unit is programming |
| wr_stb | output | 1 | Write byte strobe |
| wr_data | output | 8 | Write byte |
| wr_go | output | 1 | Start programming pulse |
| prot_cfg | output | 3 | {wpen, bp[1:0]} |

## Verification
The bench reads across the top of the array to catch an address counter that stops or wraps in the wrong place. It writes across the end of a page, where a design that carries into the upper address bits would strobe the wrong location. It sends write commands with the latch clear and with wr_busy high, and sends undefined command codes. A faulty decoder would then emit strobes, set the latch or drive the output. Status reads taken after a write frame show whether the latch was cleared and whether the busy pattern 8'hFF replaces the real status.

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  output logic              so,
  output logic              so_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  input  logic              wr_allow,
  input  logic              wr_busy,
  output logic              wr_stb,
  output logic [7:0]        wr_data,
  output logic              wr_go,
  output logic [2:0]        prot_cfg
);
  typedef enum logic [2:0] {C_OPC, C_IGN, C_READ, C_RDSR, C_WRITE, C_WRSR} cmd_t;

  logic [2:0] cs_s, sck_s;
  logic [1:0] si_s;
  logic [2:0] bitc;
  logic [1:0] bytc;
  logic [7:0] sh_in, sh_out;
  logic [ADDR_W-1:0] addr;
  cmd_t cmd;
  logic wel, wpen, oe, reload, got, adv;
  logic [1:0] bp;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_s <= '1; sck_s <= '0; si_s <= '0;
    end else begin
      cs_s <= {cs_s[1:0], cs_n};
      sck_s <= {sck_s[1:0], sck};
      si_s <= {si_s[0], si};
    end
  end

  wire sel   = ~cs_s[1];
  wire rise  = sel & sck_s[1] & ~sck_s[2];
  wire fall  = sel & ~sck_s[1] & sck_s[2];
  wire cs_up = cs_s[1] & ~cs_s[2];
  wire last  = rise & (bitc == 3'd7);
  wire [7:0] byte_in = {sh_in[6:0], si_s[1]};
  wire [7:0] status  = wr_busy ? 8'hFF : {wpen, 3'b000, bp, wel, 1'b0};
  wire [7:0] nxt     = (cmd == C_RDSR) ? status : mem_rdata;

  assign so       = sh_out[7];
  assign so_en    = oe & ~cs_n;
  assign mem_addr = addr;
  assign prot_cfg = {wpen, bp};

  always_ff @(posedge clk) begin
    if (rst) begin
      bitc <= '0; bytc <= '0; sh_in <= '0; sh_out <= '0; addr <= '0;
      cmd <= C_OPC; wel <= 1'b0; wpen <= 1'b0; bp <= '0; oe <= 1'b0;
      reload <= 1'b0; got <= 1'b0; adv <= 1'b0;
      wr_stb <= 1'b0; wr_data <= '0; wr_go <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      wr_go  <= 1'b0;
      adv    <= 1'b0;
      if (adv) addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + 1'b1;
      if (cs_up) begin
        bitc <= '0; bytc <= '0; cmd <= C_OPC; oe <= 1'b0; reload <= 1'b0; got <= 1'b0;
        if (got) begin
          wr_go <= 1'b1;
          wel   <= 1'b0;
        end
      end else begin
        if (rise) begin
          sh_in <= byte_in;
          bitc  <= bitc + 1'b1;
        end
        if (last) begin
          if (bytc != 2'd3) bytc <= bytc + 1'b1;
          case (cmd)
            C_OPC: begin
              cmd <= C_IGN;
              if (byte_in[7:4] == 4'h0 && (!wr_busy || byte_in[2:0] == 3'b101)) begin
                case (byte_in[2:0])
                  3'b110: wel <= 1'b1;
                  3'b100: wel <= 1'b0;
                  3'b101: begin cmd <= C_RDSR; reload <= 1'b1; end
                  3'b001: cmd <= wel ? C_WRSR : C_IGN;
                  3'b011: cmd <= C_READ;
                  3'b010: cmd <= wel ? C_WRITE : C_IGN;
                  default: cmd <= C_IGN;
                endcase
              end
            end
            C_READ, C_WRITE: begin
              if (bytc == 2'd1) addr[ADDR_W-1:8] <= byte_in[ADDR_W-9:0];
              if (bytc == 2'd2) begin
                addr[7:0] <= byte_in;
                if (cmd == C_READ) reload <= 1'b1;
              end
              if (bytc == 2'd3) begin
                if (cmd == C_READ) begin
                  addr   <= addr + 1'b1;
                  reload <= 1'b1;
                end else begin
                  adv <= 1'b1;
                  if (wr_allow) begin
                    wr_stb  <= 1'b1;
                    wr_data <= byte_in;
                    got     <= 1'b1;
                  end
                end
              end
            end
            C_WRSR: if (bytc == 2'd1 && wr_allow) begin
              wpen <= byte_in[7];
              bp   <= byte_in[3:2];
              got  <= 1'b1;
            end
            C_RDSR: reload <= 1'b1;
            default: ;
          endcase
        end
        if (fall) begin
          if (reload) begin
            sh_out <= nxt;
            oe     <= 1'b1;
            reload <= 1'b0;
          end else begin
            sh_out <= {sh_out[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_eeprom_slave_chk.sv
module spi_eeprom_slave_chk #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              so_en,
  input logic              wr_stb,
  input logic              wr_go,
  input logic              wr_busy,
  input logic              wel,
  input logic [ADDR_W-1:0] mem_addr
);
  a_r11_quiet_when_deselected: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !so_en);
  a_r8_go_clears_latch: assert property (@(posedge clk) disable iff (rst)
    wr_go |=> !wel);
  a_r6_strobe_needs_latch: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> wel);
  a_r7_page_wrap: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> (mem_addr[PAGE_W-1:0] == $past(mem_addr[PAGE_W-1:0]) + 1'b1) &&
               (mem_addr[ADDR_W-1:PAGE_W] == $past(mem_addr[ADDR_W-1:PAGE_W])));
  a_r8_single_event: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_stb, wr_go}));
  a_r8_go_is_pulse: assert property (@(posedge clk) disable iff (rst)
    wr_go |=> !wr_go);
endmodule

bind spi_eeprom_slave spi_eeprom_slave_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .so_en(so_en), .wr_stb(wr_stb), .wr_go(wr_go),
  .wr_busy(wr_busy), .wel(wel), .mem_addr(mem_addr));

// File: tb/tb_spi_eeprom_slave.sv
module tb_spi_eeprom_slave;
  localparam int AW = 13;
  logic clk = 0, rst = 1, cs_n = 1, sck = 0, si = 0;
  logic so, so_en, wr_stb, wr_go;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_rdata, wr_data;
  logic wr_allow, wr_busy = 0, lock_hi = 0;
  logic [2:0] prot_cfg;
  int vec = 0, bad = 0, stb_n = 0, go_n = 0;
  logic [AW-1:0] stb_a [8];
  logic [7:0] stb_d [8];
  bit en_seen;

  always #5 clk = ~clk;

  function automatic logic [7:0] mem_f(logic [AW-1:0] a);
    return a[7:0] ^ {a[12:8], 3'b101};
  endfunction

  assign mem_rdata = mem_f(mem_addr);
  assign wr_allow  = !(lock_hi && mem_addr[12:11] == 2'b11);

  spi_eeprom_slave #(.ADDR_W(AW), .PAGE_W(5)) dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .so(so), .so_en(so_en),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .wr_allow(wr_allow), .wr_busy(wr_busy),
    .wr_stb(wr_stb), .wr_data(wr_data), .wr_go(wr_go), .prot_cfg(prot_cfg));

  always @(posedge clk) begin
    if (wr_stb) begin
      if (stb_n < 8) begin stb_a[stb_n] <= mem_addr; stb_d[stb_n] <= wr_data; end
      stb_n <= stb_n + 1;
    end
    if (wr_go) go_n <= go_n + 1;
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk) si = tx[i];
      repeat (8) @(negedge clk);
      rx[i] = so;
      if (so_en) en_seen = 1;
      sck = 1;
      repeat (8) @(negedge clk);
      sck = 0;
    end
  endtask

  task automatic sel;
    @(negedge clk) cs_n = 0;
    en_seen = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic desel;
    repeat (4) @(negedge clk);
    cs_n = 1;
    repeat (12) @(negedge clk);
  endtask

  task automatic cmd1(logic [7:0] op);
    logic [7:0] r;
    sel; xfer(op, r); desel;
  endtask

  task automatic rdsr(output logic [7:0] s);
    sel; xfer(8'h05, s); xfer(8'h00, s); desel;
  endtask

  task automatic do_read(logic [7:0] op, logic [15:0] a, int n, string tag);
    logic [7:0] r;
    logic [AW-1:0] ea;
    sel;
    xfer(op, r); xfer(a[15:8], r); xfer(a[7:0], r);
    chk(!en_seen, "R11 header", en_seen, 0);
    for (int i = 0; i < n; i++) begin
      ea = AW'(a) + AW'(i);
      xfer(8'($urandom), r);
      chk(r == mem_f(ea), tag, r, mem_f(ea));
    end
    chk(en_seen, "R11 read drive", en_seen, 1);
    desel;
  endtask

  task automatic do_write(logic [7:0] op, logic [15:0] a, int n, logic [7:0] d0);
    logic [7:0] r;
    sel;
    xfer(op, r); xfer(a[15:8], r); xfer(a[7:0], r);
    for (int i = 0; i < n; i++) xfer(d0 + 8'(i), r);
    desel;
  endtask

  logic [7:0] s, r;
  int g0, s0;
  bit done = 0;

  initial begin
    void'($urandom(32'h5eed));
    repeat (4) @(negedge clk);
    rst = 0;
    repeat (4) @(negedge clk);
    chk(so_en == 0, "R11 reset", so_en, 0);
    chk(prot_cfg == 0, "R12 prot reset", prot_cfg, 0);
    rdsr(s); chk(s == 8'h00, "R12 status reset", s, 8'h00);

    cmd1(8'h06); rdsr(s); chk(s == 8'h02, "R4 latch set", s, 8'h02);
    cmd1(8'h0C); rdsr(s); chk(s == 8'h00, "R4 latch clear (bit3 dc) R1", s, 8'h00);

    sel; xfer(8'h05, s); xfer(8'h00, s); xfer(8'h00, r); desel;
    chk(r == 8'h00, "R5 repeated status", r, 8'h00);

    do_read(8'h03, 16'h0123, 4, "R2 read");
    do_read(8'h0B, 16'hE000 | 16'h1FFE, 4, "R2 wrap, high addr ignored, R1 bit3");
    for (int k = 0; k < 20; k++)
      do_read(8'h03, 16'($urandom), 1 + ($urandom % 5), "R3 random read");

    g0 = go_n; s0 = stb_n;
    do_write(8'h02, 16'h0040, 2, 8'h11);
    chk(stb_n == s0 && go_n == g0, "R6 write without latch", stb_n - s0, 0);
    cmd1(8'h06);
    cmd1(8'h01);
    rdsr(s); chk(s == 8'h02, "R6 write ignored, latch kept", s, 8'h02);

    s0 = stb_n; g0 = go_n;
    do_write(8'h02, 16'h055E, 3, 8'hA0);
    chk(stb_n - s0 == 3, "R7 strobe count", stb_n - s0, 3);
    chk(stb_a[s0] == 13'h055E && stb_d[s0] == 8'hA0, "R7 first byte", stb_a[s0], 13'h055E);
    chk(stb_a[s0+1] == 13'h055F && stb_d[s0+1] == 8'hA1, "R7 second byte", stb_a[s0+1], 13'h055F);
    chk(stb_a[s0+2] == 13'h0540 && stb_d[s0+2] == 8'hA2, "R7 page wrap", stb_a[s0+2], 13'h0540);
    chk(go_n - g0 == 1, "R8 go pulse", go_n - g0, 1);
    rdsr(s); chk(s == 8'h00, "R8 latch cleared", s, 8'h00);

    lock_hi = 1; cmd1(8'h06); s0 = stb_n; g0 = go_n;
    do_write(8'h02, 16'h1810, 2, 8'h33);
    chk(stb_n == s0 && go_n == g0, "R7 refused bytes", stb_n - s0, 0);
    rdsr(s); chk(s == 8'h02, "R8 no go keeps latch", s, 8'h02);
    lock_hi = 0; cmd1(8'h04);

    wr_busy = 1;
    rdsr(s); chk(s == 8'hFF, "R5 busy status", s, 8'hFF);
    cmd1(8'h06);
    sel; xfer(8'h03, r); xfer(8'h00, r); xfer(8'h00, r); xfer(8'h00, r); desel;
    chk(!en_seen, "R9 read dropped while busy", en_seen, 0);
    wr_busy = 0;
    rdsr(s); chk(s == 8'h00, "R9 latch set dropped", s, 8'h00);

    sel; xfer(8'h07, r); xfer(8'h00, r); xfer(8'h00, r); desel;
    chk(!en_seen, "R11 unknown opcode", en_seen, 0);
    sel; xfer(8'h13, r); xfer(8'h00, r); xfer(8'h00, r); xfer(8'h00, r); desel;
    chk(!en_seen, "R1 upper opcode bits", en_seen, 0);

    cmd1(8'h06); g0 = go_n;
    sel; xfer(8'h01, r); xfer(8'h8C, r); desel;
    chk(prot_cfg == 3'b111, "R10 prot cfg", prot_cfg, 3'b111);
    chk(go_n - g0 == 1, "R8 go after status write", go_n - g0, 1);
    rdsr(s); chk(s == 8'h8C, "R10 status read back", s, 8'h8C);
    chk(so_en == 0, "R11 idle", so_en, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      vec++; bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule